// File: doc/BRIEF.md
# Configuration Retry Status Handler

This block sits between a root port's configuration requester and the link-side completion path. It accepts one configuration read or write at a time from the host. It keeps the address, byte enables, write data and direction of that request, and sends it to the link as a single-cycle request. It then waits for the completion. A completion whose status code is 2 means the target asked for the configuration request to be retried. Every other status ends the transaction, and that status and data go back to the host with a one-cycle acknowledge.

When a retry completion arrives, the block does one of two things. If the request is a read and the software-visibility enable is set, the block finishes at once and returns the substitute value 0xFFFF0001. This is 0x0001 in the low 16 bits, where the vendor ID sits, with all other bits set. The substitution applies at any register offset. In all other cases the block waits a fixed interval of one microsecond, measured by a prescaler set from the clock frequency, and sends the saved request again as a fresh one. A counter limits the number of reissues. When the limit is used up, the host gets a timeout status, all-ones data and a retry indicator that rises in the same cycle as the acknowledge.

Top module: `cfg_retry_ctl`

## Requirements
- R1: `host_req_ready` is high only when no request is outstanding. A request sampled with `host_req_valid` and `host_req_ready` both high is presented on the link port one cycle later as a single-cycle `link_req_valid` pulse. That pulse carries the sampled address, byte enables, write data and write flag.
- R2: A completion whose status is not 2 ends the transaction. One cycle after the completion is sampled, `host_ack` pulses for one cycle with the completion's status and data. Status codes are 0 = success, 1 = unsupported, 2 = retry, 4 = abort.
- R3: A retry completion (status 2) on a write, or on a read while `vis_en` is low, produces no acknowledge. Instead the saved request is sent to the link again.
- R4: A reissued request appears on the link exactly `CLK_MHZ` clock edges after the edge that samples the retry completion. This is one microsecond of delay.
- R5: A retry completion on a read while `vis_en` is high produces an acknowledge one cycle later with status 0, data 0xFFFF0001 and `host_ack_crs` low, at any address, and no reissue.
- R6: `host_ack_status` never carries the value 2.
- R7: A request that gets `MAX_RETRY` reissues, so `MAX_RETRY`+1 link requests, and still receives a retry status is acknowledged with status 7 (timeout), data 0xFFFFFFFF and `host_ack_crs` high. The reissue budget starts again with every new request.
- R8: While a request is outstanding, new requests are ignored, and the values on the link request fields stay as they were captured, whatever the host inputs do.
- R9: During and right after reset, `host_req_ready` is high and `host_ack`, `host_ack_crs` and `link_req_valid` are low. A reset in the middle of a sequence abandons it.
- R10: `host_ack_crs` is high only in a cycle where `host_ack` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vis_en | input | 1 | Software visibility of retry status enabled |
| host_req_valid | input | 1 | Host presents a configuration request |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | ADDR_W | Configuration register address |
| host_req_be | input | 4 | Byte enables |
| host_req_wdata | input | 32 | Write data |
| host_req_ready | output | 1 | Block is idle and accepts a request |
| host_ack | output | 1 | One-cycle final acknowledge |
| host_ack_status | output | 3 | Final status (0, 1, 4 or 7) |
| host_ack_rdata | output | 32 | Final read data |
| host_ack_crs | output | 1 | Retry indicator, only with an acknowledge |
| link_req_valid | output | 1 | One-cycle request toward the link |
| link_req_write | output | 1 | Saved direction |
| link_req_addr | output | ADDR_W | Saved address |
| link_req_be | output | 4 | Saved byte enables |
| link_req_wdata | output | 32 | Saved write data |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion data |

## Verification
The properties assume that completions arrive only for the request in flight, never in the cycle that sends it, and at most once for each link request. They also assume that `vis_en` stays constant while a transaction is open. The bench meets all of this with a responder that answers each link pulse exactly once, one cycle after seeing it, and that holds `vis_en` fixed for each vector. It also drives unrelated host requests and field values during busy periods, so that the claims about ignoring input and holding values are tested, not assumed.

// File: rtl/cfgrt_pkg.sv
package cfgrt_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int STS_W  = 3;

    localparam logic [STS_W-1:0]  STS_OK      = 3'd0;
    localparam logic [STS_W-1:0]  STS_RETRY   = 3'd2;
    localparam logic [STS_W-1:0]  STS_TIMEOUT = 3'd7;
    localparam logic [DATA_W-1:0] VIS_VALUE   = 32'hFFFF_0001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DELAY = 2'd3
    } seq_state_e;
endpackage

// File: rtl/cfgrt_usec_timer.sv
module cfgrt_usec_timer #(
    parameter int TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == CW'(TICKS - 1));

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || expire) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cfgrt_req_hold.sv
module cfgrt_req_hold
    import cfgrt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    output logic [DATA_W-1:0] out_wdata
);
    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } saved_t;

    saved_t sv_d, sv_q;

    always_comb begin
        sv_d = sv_q;
        if (load) begin
            sv_d.write = in_write;
            sv_d.addr  = in_addr;
            sv_d.be    = in_be;
            sv_d.wdata = in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_q <= '0;
        end else begin
            sv_q <= sv_d;
        end
    end

    assign out_write = sv_q.write;
    assign out_addr  = sv_q.addr;
    assign out_be    = sv_q.be;
    assign out_wdata = sv_q.wdata;
endmodule

// File: rtl/cfg_retry_ctl.sv
module cfg_retry_ctl
    import cfgrt_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CLK_MHZ   = 200,
    parameter int MAX_RETRY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vis_en,
    input  logic              host_req_valid,
    input  logic              host_req_write,
    input  logic [ADDR_W-1:0] host_req_addr,
    input  logic [3:0]        host_req_be,
    input  logic [31:0]       host_req_wdata,
    output logic              host_req_ready,
    output logic              host_ack,
    output logic [2:0]        host_ack_status,
    output logic [31:0]       host_ack_rdata,
    output logic              host_ack_crs,
    output logic              link_req_valid,
    output logic              link_req_write,
    output logic [ADDR_W-1:0] link_req_addr,
    output logic [3:0]        link_req_be,
    output logic [31:0]       link_req_wdata,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic [31:0]       cpl_data
);
    localparam int TRY_W = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [TRY_W-1:0]  tries;
        logic              ack;
        logic [STS_W-1:0]  sts;
        logic [DATA_W-1:0] rdata;
        logic              crs;
    } ctl_t;

    ctl_t c_d, c_q;
    logic load;
    logic tmr_expire;
    logic in_wait;

    assign load    = (c_q.st == ST_IDLE) && host_req_valid;
    assign in_wait = (c_q.st == ST_WAIT);

    cfgrt_req_hold #(.ADDR_W(ADDR_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_write (host_req_write),
        .in_addr  (host_req_addr),
        .in_be    (host_req_be),
        .in_wdata (host_req_wdata),
        .out_write(link_req_write),
        .out_addr (link_req_addr),
        .out_be   (link_req_be),
        .out_wdata(link_req_wdata)
    );

    cfgrt_usec_timer #(.TICKS(CLK_MHZ)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.st == ST_DELAY),
        .expire(tmr_expire)
    );

    always_comb begin
        c_d     = c_q;
        c_d.ack = 1'b0;
        c_d.crs = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (host_req_valid) begin
                    c_d.st    = ST_SEND;
                    c_d.tries = '0;
                end
            end
            ST_SEND: begin
                c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (cpl_valid) begin
                    if (cpl_status != STS_RETRY) begin
                        c_d.ack   = 1'b1;
                        c_d.sts   = cpl_status;
                        c_d.rdata = cpl_data;
                        c_d.st    = ST_IDLE;
                    end else if (vis_en && !link_req_write) begin
                        c_d.ack   = 1'b1;
                        c_d.sts   = STS_OK;
                        c_d.rdata = VIS_VALUE;
                        c_d.st    = ST_IDLE;
                    end else if (c_q.tries == TRY_W'(MAX_RETRY)) begin
                        c_d.ack   = 1'b1;
                        c_d.crs   = 1'b1;
                        c_d.sts   = STS_TIMEOUT;
                        c_d.rdata = '1;
                        c_d.st    = ST_IDLE;
                    end else begin
                        c_d.tries = c_q.tries + 1'b1;
                        c_d.st    = ST_DELAY;
                    end
                end
            end
            ST_DELAY: begin
                if (tmr_expire) begin
                    c_d.st = ST_SEND;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign host_req_ready  = (c_q.st == ST_IDLE);
    assign link_req_valid  = (c_q.st == ST_SEND);
    assign host_ack        = c_q.ack;
    assign host_ack_status = c_q.sts;
    assign host_ack_rdata  = c_q.rdata;
    assign host_ack_crs    = c_q.crs;
endmodule

// File: rtl/cfg_retry_ctl_chk.sv
module cfg_retry_ctl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vis_en,
    input logic              in_wait,
    input logic              host_req_valid,
    input logic              host_req_ready,
    input logic              host_ack,
    input logic [2:0]        host_ack_status,
    input logic [31:0]       host_ack_rdata,
    input logic              host_ack_crs,
    input logic              link_req_valid,
    input logic              link_req_write,
    input logic [ADDR_W-1:0] link_req_addr,
    input logic [3:0]        link_req_be,
    input logic [31:0]       link_req_wdata,
    input logic              cpl_valid,
    input logic [2:0]        cpl_status,
    input logic [31:0]       cpl_data
);
    AST_ACCEPT_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_valid && host_req_ready |=> link_req_valid); // R1
    AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        link_req_valid |=> !link_req_valid); // R1
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        link_req_valid |-> !host_req_ready); // R1
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R2
    AST_PASS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && cpl_valid && cpl_status != 3'd2 |=>
        host_ack && host_ack_status == $past(cpl_status)
        && host_ack_rdata == $past(cpl_data)); // R2
    AST_REISSUE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && cpl_valid && cpl_status == 3'd2 && !(vis_en && !link_req_write)
        |=> !host_ack || host_ack_crs); // R3
    AST_VIS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && cpl_valid && cpl_status == 3'd2 && vis_en && !link_req_write
        |=> host_ack && host_ack_rdata == 32'hFFFF_0001
        && host_ack_status == 3'd0 && !host_ack_crs); // R5
    AST_NO_RETRY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> host_ack_status != 3'd2); // R6
    AST_TIMEOUT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_crs |-> host_ack_status == 3'd7 && host_ack_rdata == 32'hFFFF_FFFF); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req_ready && !$past(host_req_ready) |->
        $stable(link_req_addr) && $stable(link_req_be)
        && $stable(link_req_wdata) && $stable(link_req_write)); // R8
    AST_CRS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_crs |-> host_ack); // R10
endmodule

bind cfg_retry_ctl cfg_retry_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .vis_en         (vis_en),
    .in_wait        (in_wait),
    .host_req_valid (host_req_valid),
    .host_req_ready (host_req_ready),
    .host_ack       (host_ack),
    .host_ack_status(host_ack_status),
    .host_ack_rdata (host_ack_rdata),
    .host_ack_crs   (host_ack_crs),
    .link_req_valid (link_req_valid),
    .link_req_write (link_req_write),
    .link_req_addr  (link_req_addr),
    .link_req_be    (link_req_be),
    .link_req_wdata (link_req_wdata),
    .cpl_valid      (cpl_valid),
    .cpl_status     (cpl_status),
    .cpl_data       (cpl_data)
);

// File: tb/test_cfg_retry_ctl.sv
module test_cfg_retry_ctl;
    localparam int ADDR_W = 12;
    localparam int US     = 200;
    localparam int MAXR   = 3;
    localparam int NVEC   = 9;

    typedef struct packed {
        logic              wr;
        logic              vis;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        ncrs;
        logic [2:0]        fsts;
        logic [31:0]       fdata;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 12'h000, 4'd0, 3'd0, 32'h1234_5678},
        '{1'b1, 1'b0, 12'h010, 4'd2, 3'd0, 32'h0000_0000},
        '{1'b0, 1'b1, 12'h000, 4'd1, 3'd0, 32'hAAAA_5555},
        '{1'b0, 1'b1, 12'h0A4, 4'd1, 3'd0, 32'hAAAA_5555},
        '{1'b1, 1'b1, 12'h004, 4'd1, 3'd0, 32'h0000_0000},
        '{1'b0, 1'b0, 12'h008, 4'd5, 3'd0, 32'h0BAD_0BAD},
        '{1'b0, 1'b0, 12'h00C, 4'd3, 3'd0, 32'h8086_1AF4},
        '{1'b0, 1'b0, 12'h100, 4'd0, 3'd1, 32'h0000_0000},
        '{1'b0, 1'b0, 12'h104, 4'd1, 3'd4, 32'h0000_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vis_en = 1'b0;
    logic host_req_valid = 1'b0;
    logic host_req_write = 1'b0;
    logic [ADDR_W-1:0] host_req_addr = '0;
    logic [3:0] host_req_be = '0;
    logic [31:0] host_req_wdata = '0;
    logic host_req_ready, host_ack, host_ack_crs, link_req_valid, link_req_write;
    logic [2:0] host_ack_status;
    logic [31:0] host_ack_rdata, link_req_wdata;
    logic [ADDR_W-1:0] link_req_addr;
    logic [3:0] link_req_be;
    logic cpl_valid = 1'b0;
    logic [2:0] cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_retry_ctl #(.ADDR_W(ADDR_W), .CLK_MHZ(US), .MAX_RETRY(MAXR)) i_cfg_retry_ctl (
        .clk(clk), .rst_n(rst_n), .vis_en(vis_en),
        .host_req_valid(host_req_valid), .host_req_write(host_req_write),
        .host_req_addr(host_req_addr), .host_req_be(host_req_be),
        .host_req_wdata(host_req_wdata), .host_req_ready(host_req_ready),
        .host_ack(host_ack), .host_ack_status(host_ack_status),
        .host_ack_rdata(host_ack_rdata), .host_ack_crs(host_ack_crs),
        .link_req_valid(link_req_valid), .link_req_write(link_req_write),
        .link_req_addr(link_req_addr), .link_req_be(link_req_be),
        .link_req_wdata(link_req_wdata), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_vec(input vec_t v);
        logic [31:0] wd = 32'hC0DE_0000 | 32'(v.addr);
        logic [3:0]  be = v.addr[3:0] ^ 4'hF;
        int exp_sent;
        logic [2:0] exp_sts;
        logic [31:0] exp_data;
        logic exp_crs;
        int sent = 0;
        int prev = 0;
        int guard;
        bit done = 1'b0;
        if (v.ncrs > 0 && v.vis && !v.wr) begin
            exp_sent = 1; exp_sts = 3'd0; exp_data = 32'hFFFF_0001; exp_crs = 1'b0;
        end else if (int'(v.ncrs) > MAXR) begin
            exp_sent = MAXR + 1; exp_sts = 3'd7; exp_data = 32'hFFFF_FFFF; exp_crs = 1'b1;
        end else begin
            exp_sent = int'(v.ncrs) + 1; exp_sts = v.fsts; exp_data = v.fdata; exp_crs = 1'b0;
        end
        @(negedge clk);
        chk(host_req_ready, "R1 ready when idle", 32'(host_req_ready), 32'd1);
        vis_en = v.vis;
        host_req_valid = 1'b1;
        host_req_write = v.wr;
        host_req_addr = v.addr;
        host_req_be = be;
        host_req_wdata = wd;
        @(negedge clk);
        // R8: a competing request with different fields while busy
        host_req_write = ~v.wr;
        host_req_addr = ~v.addr;
        host_req_be = ~be;
        host_req_wdata = ~wd;
        while (!done) begin
            guard = 0;
            while (!link_req_valid && guard < 2 * US) begin
                @(negedge clk);
                guard++;
            end
            chk(link_req_valid, "R3 link request present", 32'(link_req_valid), 32'd1);
            chk(!host_req_ready, "R8 ready low while busy", 32'(host_req_ready), 32'd0);
            chk(link_req_addr == v.addr && link_req_be == be && link_req_wdata == wd
                && link_req_write == v.wr, "R8 R1 saved fields",
                32'(link_req_addr), 32'(v.addr));
            sent++;
            if (sent > 1) begin
                chk(cyc - prev == US + 2, "R4 reissue spacing", 32'(cyc - prev), 32'(US + 2));
            end
            prev = cyc;
            @(negedge clk);
            host_req_valid = 1'b0;
            cpl_valid = 1'b1;
            cpl_status = (sent <= int'(v.ncrs)) ? 3'd2 : v.fsts;
            cpl_data = (sent <= int'(v.ncrs)) ? 32'hDEAD_BEEF : v.fdata;
            @(negedge clk);
            cpl_valid = 1'b0;
            if (host_ack) begin
                done = 1'b1;
                chk(host_ack_status == exp_sts, "R2 R5 R6 R7 ack status",
                    32'(host_ack_status), 32'(exp_sts));
                chk(host_ack_rdata == exp_data, "R2 R5 R7 ack data", host_ack_rdata, exp_data);
                chk(host_ack_crs == exp_crs, "R7 R10 retry indicator",
                    32'(host_ack_crs), 32'(exp_crs));
                @(negedge clk);
                chk(!host_ack && host_req_ready, "R2 ack single cycle",
                    32'(host_ack), 32'd0);
            end else begin
                chk(!host_ack_crs, "R10 indicator without ack", 32'(host_ack_crs), 32'd0);
                if (sent >= exp_sent + 1) begin
                    done = 1'b1;
                end
            end
        end
        chk(sent == exp_sent, "R3 R7 link request count", 32'(sent), 32'(exp_sent));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(host_req_ready && !host_ack && !link_req_valid && !host_ack_crs,
            "R9 state in reset", {host_req_ready, host_ack, link_req_valid, host_ack_crs},
            32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_req_ready && !host_ack && !link_req_valid && !host_ack_crs,
            "R9 state after reset", {host_req_ready, host_ack, link_req_valid, host_ack_crs},
            32'h8);
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end
        // R9: reset in the middle of a retry sequence abandons it
        @(negedge clk);
        vis_en = 1'b0;
        host_req_valid = 1'b1;
        host_req_write = 1'b0;
        host_req_addr = 12'h020;
        @(negedge clk);
        host_req_valid = 1'b0;
        @(negedge clk);
        cpl_valid = 1'b1;
        cpl_status = 3'd2;
        @(negedge clk);
        cpl_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < US + 4; k++) begin
            @(negedge clk);
            if (link_req_valid || !host_req_ready) begin
                chk(1'b0, "R9 sequence abandoned", 32'(link_req_valid), 32'd0);
                break;
            end
        end
        chk(host_req_ready, "R9 idle after mid-sequence reset", 32'(host_req_ready), 32'd1);
        // R5 again after reset, at a high offset
        run_vec('{1'b0, 1'b1, 12'hFFC, 4'd1, 3'd0, 32'h0});
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule